// File: doc/BRIEF.md
# Flyby Address Substitution Counter

This block sits in front of local memories so that each one can serve as the passive, peripheral end of a memory-to-memory flyby transfer. While a flyby runs, the memory does not decode the address phase on the bus. Instead, a local pointer supplies the address for every beat that the DMA engine acknowledges with valid data. After each such beat, the pointer moves forward by one 8-byte unit. When the block sees no qualified beat, it forwards the bus address to the memory unchanged.

Software sets each pointer through a small write port, in 8-byte units: the value written is the byte address divided by 8. The block contains `NUM_CH` independent pointers, two by default, called channel 0 and channel 1. Each pointer has its own acknowledge input, bus address input and memory address output. The data-valid qualifier is shared, so the two channels can run at the same time. The memory array and the DMA engine are not part of this block.

Top module: `flyby_subst`

## Requirements
- R1: After reset, every pointer holds 0, so the first qualified beat on a channel presents memory address 0.
- R2: On a channel where `dma_ack[i]` and `data_valid` are not both 1, `mem_addr[i]` equals `bus_addr[i]` in the same cycle.
- R3: On a qualified beat (`dma_ack[i]` and `data_valid` both 1), `mem_addr[i]` equals the pointer shifted left by 3, with bits [2:0] zero, whatever value `bus_addr[i]` holds.
- R4: Each qualified beat without a write to that channel advances its pointer by exactly one 8-byte unit, so the next qualified beat presents an address 8 higher.
- R5: Acknowledge without data-valid, or data-valid without acknowledge, leaves the pointer unchanged.
- R6: A write with `cfg_we`=1 and `cfg_sel`=i loads `cfg_data` into pointer i, and the next qualified beat on channel i presents `cfg_data`×8.
- R7: A write that lands in the same cycle as a qualified beat on that channel does not change that beat's address. The pointer then takes the written value, without the increment, and the following beat uses it.
- R8: A write or a beat on one channel leaves the other channel's pointer and output unchanged.
- R9: The pointer wraps from its largest value (all ones, `ADDR_W-3` bits) to 0 on a qualified beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Pointer write strobe |
| cfg_sel | input | CH_W | Channel index for the write |
| cfg_data | input | ADDR_W-3 | Start address in 8-byte units |
| dma_ack | input | NUM_CH | DMA acknowledge, one per channel |
| data_valid | input | 1 | Shared data-valid qualifier |
| bus_addr | input | NUM_CH×ADDR_W | Incoming bus byte address per channel |
| mem_addr | output | NUM_CH×ADDR_W | Address sent to each memory |

## Verification
The bench drives each channel through several patterns: long runs of qualified beats, acknowledge without data-valid, data-valid without acknowledge, and idle cycles that carry arbitrary bus addresses. Comparing these separates pointer advance from pass-through and from wrongly holding the pointer. Writes are placed on idle cycles and on the same cycle as a beat, to show the write priority and when the new value takes effect. Writes to one channel while the other channel beats reveal any coupling between channels. A final mixed random section checks every cycle against a behavioural model.

// File: rtl/flyby_pkg.sv
package flyby_pkg;

    localparam int UNIT_SHIFT = 3;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } ptr_op_e;

    // write wins over a beat in the same cycle; the beat still uses the old value
    function automatic ptr_op_e pick_op(input logic wr_hit, input logic beat);
        if (wr_hit)
            return OP_LOAD;
        else if (beat)
            return OP_STEP;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/flyby_ptr.sv
module flyby_ptr
    import flyby_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             beat,
    output logic [CNT_W-1:0] ptr
);

    ptr_op_e op;

    always_comb op = pick_op(load, beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            unique case (op)
                OP_LOAD: ptr <= load_val;
                OP_STEP: ptr <= ptr + CNT_W'(1);
                default: ptr <= ptr;
            endcase
        end
    end

    // R4 / R9: one unit per unloaded beat, modulo the width
    a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
        (beat && !load) |=> (ptr == $past(ptr) + CNT_W'(1)));

    // R5: no beat and no write means no movement
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!beat && !load) |=> $stable(ptr));

    // R6 / R7: a write always lands, even together with a beat
    a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> (ptr == $past(load_val)));

endmodule

// File: rtl/flyby_addr_mux.sv
module flyby_addr_mux
    import flyby_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = ADDR_W - UNIT_SHIFT
) (
    input  logic              qual,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  ptr,
    output logic [ADDR_W-1:0] mem_addr
);

    logic [ADDR_W-1:0] sub_addr;

    always_comb begin
        sub_addr = {ptr, {UNIT_SHIFT{1'b0}}};
        mem_addr = qual ? sub_addr : bus_addr;
    end

    // R3: substituted addresses are always 8-byte aligned
    always_comb begin
        if (qual)
            a_r3_aligned: assert (mem_addr[UNIT_SHIFT-1:0] == '0);
    end

endmodule

// File: rtl/flyby_subst.sv
module flyby_subst
    import flyby_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 16,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int CNT_W  = ADDR_W - UNIT_SHIFT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [CH_W-1:0]               cfg_sel,
    input  logic [CNT_W-1:0]              cfg_data,
    input  logic [NUM_CH-1:0]             dma_ack,
    input  logic                          data_valid,
    input  logic [NUM_CH-1:0][ADDR_W-1:0] bus_addr,
    output logic [NUM_CH-1:0][ADDR_W-1:0] mem_addr
);

    logic [NUM_CH-1:0]            qual;
    logic [NUM_CH-1:0]            wr_hit;
    logic [NUM_CH-1:0][CNT_W-1:0] ptr;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_comb begin
            qual[i]   = dma_ack[i] & data_valid;
            wr_hit[i] = cfg_we && (cfg_sel == CH_W'(i));
        end

        flyby_ptr #(.CNT_W(CNT_W)) u_ptr (
            .clk      (clk),
            .rst      (rst),
            .load     (wr_hit[i]),
            .load_val (cfg_data),
            .beat     (qual[i]),
            .ptr      (ptr[i])
        );

        flyby_addr_mux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mux (
            .qual     (qual[i]),
            .bus_addr (bus_addr[i]),
            .ptr      (ptr[i]),
            .mem_addr (mem_addr[i])
        );

        // R2: port-level pass-through when the beat is not qualified
        a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
            !(dma_ack[i] && data_valid) |-> (mem_addr[i] == bus_addr[i]));

        // R8: a channel that neither beats nor is written keeps its next output
        a_r8_isolated: assert property (@(posedge clk) disable iff (rst)
            (!(dma_ack[i] && data_valid) && !(cfg_we && cfg_sel == CH_W'(i)))
            |=> $stable(ptr[i]));
    end

endmodule

// File: tb/tb_flyby_subst.sv
module tb_flyby_subst;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = ADDR_W - 3;
    localparam int CH_W   = 1;

    logic                          clk = 1'b0;
    logic                          rst;
    logic                          cfg_we;
    logic [CH_W-1:0]               cfg_sel;
    logic [CNT_W-1:0]              cfg_data;
    logic [NUM_CH-1:0]             dma_ack;
    logic                          data_valid;
    logic [NUM_CH-1:0][ADDR_W-1:0] bus_addr;
    logic [NUM_CH-1:0][ADDR_W-1:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";
    logic [CNT_W-1:0] m_ptr [NUM_CH];

    always #2 clk = ~clk;

    flyby_subst #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .dma_ack(dma_ack), .data_valid(data_valid),
        .bus_addr(bus_addr), .mem_addr(mem_addr)
    );

    task automatic check(input string t, input int ch,
                         input logic [ADDR_W-1:0] got, input logic [ADDR_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s ch%0d got %h expected %h", t, ch, got, exp);
        end
    endtask

    // inputs already set at the negedge; compare, then advance model at the edge
    task automatic step();
        #1;
        for (int c = 0; c < NUM_CH; c++) begin
            logic [ADDR_W-1:0] e;
            e = (dma_ack[c] && data_valid) ? {m_ptr[c], 3'b000} : bus_addr[c];
            check(tag, c, mem_addr[c], e);
        end
        @(posedge clk);
        for (int c = 0; c < NUM_CH; c++) begin
            if (cfg_we && int'(cfg_sel) == c) m_ptr[c] = cfg_data;
            else if (dma_ack[c] && data_valid) m_ptr[c] = m_ptr[c] + 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] ack, input logic dv, input logic we,
                         input int sel, input logic [CNT_W-1:0] d);
        dma_ack    = ack;
        data_valid = dv;
        cfg_we     = we;
        cfg_sel    = CH_W'(sel);
        cfg_data   = d;
        for (int c = 0; c < NUM_CH; c++) bus_addr[c] = ADDR_W'($urandom);
        step();
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(2'b00, 1'b0, 1'b0, 0, '0);
        drive(2'b00, 1'b0, 1'b0, 0, '0);
        rst = 1'b0;
        for (int c = 0; c < NUM_CH; c++) m_ptr[c] = '0;
        // R1: first qualified beats after reset give address 0
        tag = "R1";
        drive(2'b11, 1'b1, 1'b0, 0, '0);
        // R4: consecutive beats on both channels
        tag = "R4";
        for (int k = 0; k < 6; k++) drive(2'b11, 1'b1, 1'b0, 0, '0);
        // R5: ack without valid, valid without ack
        tag = "R5";
        drive(2'b11, 1'b0, 1'b0, 0, '0);
        drive(2'b00, 1'b1, 1'b0, 0, '0);
        drive(2'b11, 1'b1, 1'b0, 0, '0);
        // R2: idle cycles pass any bus address
        tag = "R2";
        for (int k = 0; k < 8; k++) drive(2'($urandom), 1'b0, 1'b0, 0, '0);
        // R6: idle write then beat
        tag = "R6";
        drive(2'b00, 1'b0, 1'b1, 0, 13'h0ABC);
        drive(2'b01, 1'b1, 1'b0, 0, '0);
        // R7: write together with a beat
        tag = "R7";
        drive(2'b01, 1'b1, 1'b1, 0, 13'h0155);
        drive(2'b01, 1'b1, 1'b0, 0, '0);
        drive(2'b01, 1'b1, 1'b0, 0, '0);
        // R8: writes to channel 1 while channel 0 beats, and the reverse
        tag = "R8";
        drive(2'b01, 1'b1, 1'b1, 1, 13'h1000);
        drive(2'b11, 1'b1, 1'b0, 0, '0);
        drive(2'b10, 1'b1, 1'b1, 0, 13'h0007);
        drive(2'b11, 1'b1, 1'b0, 0, '0);
        // R9: wrap from the top of the range
        tag = "R9";
        drive(2'b00, 1'b0, 1'b1, 1, 13'h1FFE);
        for (int k = 0; k < 4; k++) drive(2'b10, 1'b1, 1'b0, 0, '0);
        // R3: mixed traffic with random bus addresses during beats
        tag = "R3";
        for (int k = 0; k < 400; k++)
            drive(2'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0),
                  int'($urandom_range(0, 1)), CNT_W'($urandom));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule